// File: doc/BRIEF.md
# Network Controller Command and Status Register

This block is the host-facing command and status register of a network controller. The host sees two 32-bit words. Word 0 holds a 16-bit status half and a 16-bit command half. Word 1 holds a general pointer. The status half carries event flags and the current states of the command and receive engines. The host clears event flags by writing ones to them. The command half carries two command fields, one for the command unit and one for the receive unit. It also carries an interrupt mask bit and a bit that raises a software interrupt.

A nonzero command field is offered to its engine together with the pointer register, through a valid/ready handshake. The field returns to zero once the engine accepts the command. Software can therefore poll the command half until both fields read zero before it writes the next command. The engines report events on one-cycle pulse inputs. A single level interrupt output is high while any event flag is set and the mask is clear.

Top module: `nic_cmdstat`

## Requirements
- R1: After reset all event flags read 0, both command fields read 0, the mask bit (command bit 8, bus bit 24 of word 0) reads 1, the pointer reads 0 and `irq` is low.
- R2: A 1 on `evt_set[i]` sets status bit 8+i, and the new value is readable at the next clock edge. Bit 9 of the status half (from `evt_set[1]`) and status bits 1:0 always read 0.
- R3: A write to word 0 with `bus_be[1]` set clears every status event bit whose data bit (bus bits 15:8) is 1 and leaves the others unchanged. A write through `bus_be[0]` has no effect on the status half.
- R4: If an event pulse and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R5: A write with `bus_be[2]` loads the command-unit field from bus bits 23:20. The codes are 0 nop, 1 start, 2 resume, 4 load statistics address, 5 dump statistics, 6 load base, and 7 dump and reset. While the field is nonzero, `cu_cmd_valid` is high and `cu_cmd_code` shows the field. The field holds while `cu_cmd_ready` is low and reads 0 after the first edge at which valid and ready are both high.
- R6: The same write loads the receive-unit field from bus bits 18:16. The codes are 0 nop, 1 start, 2 resume, 4 abort, 6 load base, and 7 resume without resources. The field follows the same valid/ready/self-clear rule on the `ru_cmd_*` ports.
- R7: Word 1 is the pointer. It is written byte by byte under `bus_be`, read back on word 1, and presented on `cu_cmd_ptr` and `ru_cmd_ptr` while a command is offered.
- R8: Writing 1 to command bit 9 (bus bit 25, `bus_be[3]`) sets status bit 10 at the next edge. That command bit always reads 0.
- R9: `irq` is high exactly when the mask bit is 0 and at least one event flag is set. It responds in the same cycle the flags or the mask change.
- R10: Status bits 7:6 show `cu_state`, and status bits 5:2 show `ru_state`, without delay.
- R11: A command write in the same cycle that the engine accepts the old command leaves the newly written code in the field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 1 | Word select: 0 = status/command, 1 = pointer |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word |
| evt_set | input | 8 | Event pulses for status bits 15:8 |
| cu_state | input | 2 | Command engine state |
| ru_state | input | 4 | Receive engine state |
| cu_cmd_valid | output | 1 | Command-unit command offered |
| cu_cmd_code | output | 4 | Command-unit command code |
| cu_cmd_ptr | output | PTR_W | Pointer with command-unit command |
| cu_cmd_ready | input | 1 | Command engine accepts |
| ru_cmd_valid | output | 1 | Receive-unit command offered |
| ru_cmd_code | output | 3 | Receive-unit command code |
| ru_cmd_ptr | output | PTR_W | Pointer with receive-unit command |
| ru_cmd_ready | input | 1 | Receive engine accepts |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker watches several behaviours on every cycle: each command field holds while unaccepted and clears after acceptance, a write in the accept cycle takes precedence, event pulses always land in their flags even against a clear, the software-interrupt write raises its flag, and a held mask keeps `irq` low. Other behaviours only show up in the bench's directed scenarios and in its cycle-by-cycle reference comparison. These are the byte-lane selectivity of the clear and pointer writes, the reserved status bits reading zero, the engine state fields, and the exact read-back layout of both words.

// File: rtl/nic_cmdstat_pkg.sv
package nic_cmdstat_pkg;
   // event byte occupies status bits 15:8; bit 9 of status is reserved
   localparam logic [7:0] EVT_LIVE    = 8'hFD;
   localparam int         SWI_EVT_IDX = 2;    // status bit 10
   localparam int         CMD_HALF    = 16;   // command half starts at bus bit 16
   localparam int         CU_LSB      = 4;
   localparam int         CU_W        = 4;
   localparam int         RU_LSB      = 0;
   localparam int         RU_W        = 3;
   localparam int         MASK_BIT    = 8;
   localparam int         SWI_BIT     = 9;

   typedef struct packed {
      logic [7:0] events;
      logic [1:0] cu_st;
      logic [3:0] ru_st;
      logic [1:0] rsvd;
   } status_t;
endpackage

// File: rtl/nic_cmdstat_slot.sv
module nic_cmdstat_slot #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_code,
   input  logic         ready,
   output logic [W-1:0] code,
   output logic         valid
);
   logic [W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              code_q <= '0;
      else if (load)           code_q <= load_code;
      else if (valid && ready) code_q <= '0;
   end

   assign code  = code_q;
   assign valid = |code_q;
endmodule

// File: rtl/nic_cmdstat_events.sv
module nic_cmdstat_events #(
   parameter int           N    = 8,
   parameter logic [N-1:0] LIVE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   logic [N-1:0] flags_q;

   // set has priority over clear on the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= ((flags_q & ~clr) | set) & LIVE;
   end

   assign flags = flags_q;
endmodule

// File: rtl/nic_cmdstat_irq.sv
module nic_cmdstat_irq #(
   parameter int N       = 8,
   parameter bit REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags,
   input  logic         mask,
   output logic         irq
);
   logic raw;
   assign raw = ~mask & (|flags);

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= raw;
      end
      assign irq = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq = raw;
   end
endmodule

// File: rtl/nic_cmdstat.sv
module nic_cmdstat
   import nic_cmdstat_pkg::*;
#(
   parameter int PTR_W   = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr_en,
   input  logic             bus_addr,
   input  logic [3:0]       bus_be,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [7:0]       evt_set,
   input  logic [1:0]       cu_state,
   input  logic [3:0]       ru_state,
   output logic             cu_cmd_valid,
   output logic [3:0]       cu_cmd_code,
   output logic [PTR_W-1:0] cu_cmd_ptr,
   input  logic             cu_cmd_ready,
   output logic             ru_cmd_valid,
   output logic [2:0]       ru_cmd_code,
   output logic [PTR_W-1:0] ru_cmd_ptr,
   input  logic             ru_cmd_ready,
   output logic             irq
);
   localparam int NBYTES = PTR_W / 8;

   if (PTR_W % 8 != 0 || PTR_W < 8 || PTR_W > 32) begin : g_bad_ptr_w
      $error("nic_cmdstat: PTR_W must be 8, 16, 24 or 32");
   end

   logic             wr_w0, wr_w1, cmd_wr, ctl_wr, swi_pulse;
   logic [7:0]       evt_clr, evt_in, evt_flags;
   logic             mask_q;
   logic [PTR_W-1:0] ptr_q;
   logic [15:0]      cmd_word;
   status_t          st;

   assign wr_w0     = bus_wr_en & ~bus_addr;
   assign wr_w1     = bus_wr_en &  bus_addr;
   assign cmd_wr    = wr_w0 & bus_be[2];
   assign ctl_wr    = wr_w0 & bus_be[3];
   assign swi_pulse = ctl_wr & bus_wdata[CMD_HALF + SWI_BIT];
   assign evt_clr   = (wr_w0 & bus_be[1]) ? bus_wdata[15:8] : 8'h00;
   assign evt_in    = evt_set | (8'(swi_pulse) << SWI_EVT_IDX);

   // interrupt mask, disabled out of reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q <= 1'b1;
      else if (ctl_wr) mask_q <= bus_wdata[CMD_HALF + MASK_BIT];
   end

   // pointer, one lane per byte
   for (genvar b = 0; b < NBYTES; b++) begin : g_ptr_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  ptr_q[8*b +: 8] <= 8'h00;
         else if (wr_w1 && bus_be[b]) ptr_q[8*b +: 8] <= bus_wdata[8*b +: 8];
      end
   end

   nic_cmdstat_events #(.N(8), .LIVE(EVT_LIVE)) u_events (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (evt_in),
      .clr   (evt_clr),
      .flags (evt_flags)
   );

   nic_cmdstat_slot #(.W(CU_W)) u_cu_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cmd_wr),
      .load_code (bus_wdata[CMD_HALF + CU_LSB +: CU_W]),
      .ready     (cu_cmd_ready),
      .code      (cu_cmd_code),
      .valid     (cu_cmd_valid)
   );

   nic_cmdstat_slot #(.W(RU_W)) u_ru_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cmd_wr),
      .load_code (bus_wdata[CMD_HALF + RU_LSB +: RU_W]),
      .ready     (ru_cmd_ready),
      .code      (ru_cmd_code),
      .valid     (ru_cmd_valid)
   );

   nic_cmdstat_irq #(.N(8), .REG_OUT(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .flags (evt_flags),
      .mask  (mask_q),
      .irq   (irq)
   );

   assign cu_cmd_ptr = ptr_q;
   assign ru_cmd_ptr = ptr_q;

   always_comb begin
      cmd_word                       = 16'h0000;
      cmd_word[MASK_BIT]             = mask_q;
      cmd_word[CU_LSB +: CU_W]       = cu_cmd_code;
      cmd_word[RU_LSB +: RU_W]       = ru_cmd_code;
   end

   assign st.events = evt_flags;
   assign st.cu_st  = cu_state;
   assign st.ru_st  = ru_state;
   assign st.rsvd   = 2'b00;

   assign bus_rdata = bus_addr ? 32'(ptr_q) : {cmd_word, st};
endmodule

// File: rtl/nic_cmdstat_chk.sv
module nic_cmdstat_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_wr_en,
   input logic       bus_addr,
   input logic       be_cmd,
   input logic       be_ctl,
   input logic [9:0] cmd_wdata,
   input logic [7:0] evt_set,
   input logic       cu_cmd_valid,
   input logic [3:0] cu_cmd_code,
   input logic       cu_cmd_ready,
   input logic       ru_cmd_valid,
   input logic [2:0] ru_cmd_code,
   input logic       ru_cmd_ready,
   input logic       irq,
   input logic       mask_q,
   input logic [7:0] evt_flags
);
   logic cmd_write, swi_write, unused_chk;
   assign cmd_write  = bus_wr_en && !bus_addr && be_cmd;
   assign swi_write  = bus_wr_en && !bus_addr && be_ctl && cmd_wdata[9];
   assign unused_chk = ^{cmd_wdata[8], cmd_wdata[3]};

   AST_CU_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cu_cmd_valid && cu_cmd_ready && !cmd_write) |=> (cu_cmd_code == 4'd0)); // R5
   AST_CU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cu_cmd_valid && !cu_cmd_ready && !cmd_write) |=> (cu_cmd_valid && $stable(cu_cmd_code))); // R5
   AST_RU_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ru_cmd_valid && ru_cmd_ready && !cmd_write) |=> (ru_cmd_code == 3'd0)); // R6
   AST_RU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ru_cmd_valid && !ru_cmd_ready && !cmd_write) |=> (ru_cmd_valid && $stable(ru_cmd_code))); // R6
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_write |=> (cu_cmd_code == $past(cmd_wdata[7:4]) && ru_cmd_code == $past(cmd_wdata[2:0]))); // R11
   AST_EVT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_set & 8'hFD)) |=> ((evt_flags & $past(evt_set & 8'hFD)) == $past(evt_set & 8'hFD))); // R4
   AST_SWI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      swi_write |=> evt_flags[2]); // R8
   AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q && $past(mask_q)) |-> !irq); // R9
endmodule

bind nic_cmdstat nic_cmdstat_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr_en    (bus_wr_en),
   .bus_addr     (bus_addr),
   .be_cmd       (bus_be[2]),
   .be_ctl       (bus_be[3]),
   .cmd_wdata    (bus_wdata[25:16]),
   .evt_set      (evt_set),
   .cu_cmd_valid (cu_cmd_valid),
   .cu_cmd_code  (cu_cmd_code),
   .cu_cmd_ready (cu_cmd_ready),
   .ru_cmd_valid (ru_cmd_valid),
   .ru_cmd_code  (ru_cmd_code),
   .ru_cmd_ready (ru_cmd_ready),
   .irq          (irq),
   .mask_q       (mask_q),
   .evt_flags    (evt_flags)
);

// File: tb/nic_cmdstat_tb.sv
`timescale 1ns/1ps
module nic_cmdstat_tb;
   localparam int PTR_W = 32;

   logic             clk = 1'b0, rst_n = 1'b0;
   logic             bus_wr_en = 1'b0, bus_addr = 1'b0;
   logic [3:0]       bus_be = 4'h0;
   logic [31:0]      bus_wdata = '0, bus_rdata;
   logic [7:0]       evt_set = '0;
   logic [1:0]       cu_state = '0;
   logic [3:0]       ru_state = '0;
   logic             cu_cmd_valid, ru_cmd_valid, irq;
   logic [3:0]       cu_cmd_code;
   logic [2:0]       ru_cmd_code;
   logic [PTR_W-1:0] cu_cmd_ptr, ru_cmd_ptr;
   logic             cu_cmd_ready = 1'b0, ru_cmd_ready = 1'b0;

   nic_cmdstat #(.PTR_W(PTR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_set(evt_set), .cu_state(cu_state), .ru_state(ru_state),
      .cu_cmd_valid(cu_cmd_valid), .cu_cmd_code(cu_cmd_code), .cu_cmd_ptr(cu_cmd_ptr),
      .cu_cmd_ready(cu_cmd_ready), .ru_cmd_valid(ru_cmd_valid), .ru_cmd_code(ru_cmd_code),
      .ru_cmd_ptr(ru_cmd_ptr), .ru_cmd_ready(ru_cmd_ready), .irq(irq)
   );

   always #2.5 clk = ~clk;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference model, updated at each edge, compared 1 ns later
   logic [7:0]  m_ev;
   logic        m_mask;
   logic [3:0]  m_cu;
   logic [2:0]  m_ru;
   logic [31:0] m_ptr;
   bit          m_live = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ev = 8'h00; m_mask = 1'b1; m_cu = 4'h0; m_ru = 3'h0; m_ptr = 32'h0;
         m_live = 1'b1;
      end else begin
         logic [7:0] clr, set;
         clr = (bus_wr_en && !bus_addr && bus_be[1]) ? bus_wdata[15:8] : 8'h00;
         set = evt_set;
         if (bus_wr_en && !bus_addr && bus_be[3] && bus_wdata[25]) set[2] = 1'b1;
         m_ev = ((m_ev & ~clr) | set) & 8'hFD;
         if (bus_wr_en && !bus_addr && bus_be[3]) m_mask = bus_wdata[24];
         if (bus_wr_en && !bus_addr && bus_be[2]) begin
            m_cu = bus_wdata[23:20];
            m_ru = bus_wdata[18:16];
         end else begin
            if (m_cu != 0 && cu_cmd_ready) m_cu = 4'h0;
            if (m_ru != 0 && ru_cmd_ready) m_ru = 3'h0;
         end
         if (bus_wr_en && bus_addr)
            for (int b = 0; b < 4; b++)
               if (bus_be[b]) m_ptr[8*b +: 8] = bus_wdata[8*b +: 8];
      end
      #1;
      if (m_live && !done) begin
         logic [31:0] exp_rd;
         exp_rd = bus_addr ? m_ptr
                : {6'b0, 1'b0, m_mask, m_cu, 1'b0, m_ru, m_ev, cu_state, ru_state, 2'b00};
         chk("R2 model read word", bus_rdata, exp_rd);
         chk("R9 model irq", 32'(irq), 32'(!m_mask && (m_ev != 0)));
         chk("R5 model cu code", 32'(cu_cmd_code), 32'(m_cu));
         chk("R5 model cu valid", 32'(cu_cmd_valid), 32'(m_cu != 0));
         chk("R6 model ru code", 32'(ru_cmd_code), 32'(m_ru));
         chk("R6 model ru valid", 32'(ru_cmd_valid), 32'(m_ru != 0));
         chk("R7 model cu ptr", cu_cmd_ptr, m_ptr);
         chk("R7 model ru ptr", ru_cmd_ptr, m_ptr);
      end
   end

   // callers start just after a negedge; write covers exactly one rising edge
   task automatic wr(input logic a, input logic [3:0] be, input logic [31:0] d);
      bus_wr_en = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0; bus_be = 4'h0; bus_addr = 1'b0;
      #1;
   endtask

   task automatic pulse(input logic [7:0] v);
      evt_set = v;
      @(negedge clk);
      evt_set = 8'h00;
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset word0", bus_rdata, 32'h0100_0000);
      chk("R1 reset irq", 32'(irq), 32'h0);
      chk("R1 reset cu valid", 32'(cu_cmd_valid), 32'h0);
      bus_addr = 1'b1; #0.2;
      chk("R1 reset pointer", bus_rdata, 32'h0);
      bus_addr = 1'b0;
      @(negedge clk); rst_n = 1'b1; #1;

      wr(1'b0, 4'b1000, 32'h0000_0000);                 // unmask
      chk("R9 unmasked no events", 32'(irq), 32'h0);

      pulse(8'h80);
      chk("R2 bit15 set", 32'(bus_rdata[15:8]), 32'h80);
      chk("R9 irq on event", 32'(irq), 32'h1);
      pulse(8'h02);
      chk("R2 reserved bit9 stays 0", 32'(bus_rdata[15:8]), 32'h80);
      pulse(8'h41);
      chk("R2 bits14 and 8", 32'(bus_rdata[15:8]), 32'hC1);

      wr(1'b0, 4'b0001, 32'h0000_FFFF);
      chk("R3 byte0 write ignored", 32'(bus_rdata[15:0]), 32'hC100);
      wr(1'b0, 4'b0010, 32'h0000_4000);
      chk("R3 clear bit14 only", 32'(bus_rdata[15:8]), 32'h81);

      evt_set = 8'h01;
      wr(1'b0, 4'b0010, 32'h0000_8100);
      evt_set = 8'h00;
      @(negedge clk); #1;
      chk("R4 event beats clear", 32'(bus_rdata[15:8]), 32'h01);
      wr(1'b0, 4'b0010, 32'h0000_FF00);
      chk("R3 clear all", 32'(bus_rdata[15:8]), 32'h00);
      chk("R9 irq drops", 32'(irq), 32'h0);

      wr(1'b1, 4'b1111, 32'h1234_5678);
      wr(1'b1, 4'b0100, 32'h00AB_0000);
      bus_addr = 1'b1; #0.2;
      chk("R7 pointer bytes", bus_rdata, 32'h12AB_5678);
      bus_addr = 1'b0;

      cu_cmd_ready = 1'b0;
      wr(1'b0, 4'b0100, 32'h0010_0000);
      chk("R5 start offered", 32'(cu_cmd_code), 32'h1);
      chk("R7 ptr with command", cu_cmd_ptr, 32'h12AB_5678);
      repeat (3) @(negedge clk); #1;
      chk("R5 held without ready", 32'(cu_cmd_valid), 32'h1);
      cu_cmd_ready = 1'b1;
      @(negedge clk); cu_cmd_ready = 1'b0; #1;
      chk("R5 cleared after accept", 32'(bus_rdata[23:20]), 32'h0);

      ru_cmd_ready = 1'b1;
      wr(1'b0, 4'b0100, 32'h0004_0000);
      chk("R6 abort offered", 32'(ru_cmd_code), 32'h4);
      @(negedge clk); #1;
      chk("R6 cleared after accept", 32'(ru_cmd_code), 32'h0);
      ru_cmd_ready = 1'b0;

      wr(1'b0, 4'b1000, 32'h0200_0000);
      chk("R8 swi flag", 32'(bus_rdata[15:8]), 32'h04);
      chk("R8 swi bit reads 0", 32'(bus_rdata[25]), 32'h0);
      chk("R9 irq from swi", 32'(irq), 32'h1);
      wr(1'b0, 4'b1000, 32'h0100_0000);
      chk("R9 mask hides pending", 32'(irq), 32'h0);
      wr(1'b0, 4'b1000, 32'h0000_0000);
      chk("R9 unmask shows pending", 32'(irq), 32'h1);
      wr(1'b0, 4'b0010, 32'h0000_0400);

      cu_state = 2'b10; ru_state = 4'b1100; #0.2;
      chk("R10 engine states", 32'(bus_rdata[7:0]), 32'hB0);
      @(negedge clk); cu_state = 2'b00; ru_state = 4'b0000; #1;

      cu_cmd_ready = 1'b1;
      wr(1'b0, 4'b0100, 32'h0020_0000);
      wr(1'b0, 4'b0100, 32'h0050_0000);
      chk("R11 new write wins", 32'(cu_cmd_code), 32'h5);
      @(negedge clk); #1;
      chk("R5 cleared after second accept", 32'(cu_cmd_code), 32'h0);

      ru_cmd_ready = 1'b1;
      wr(1'b0, 4'b0100, 32'h0077_0000);
      chk("R5 code 7 offered", 32'(cu_cmd_code), 32'h7);
      chk("R6 code 7 offered", 32'(ru_cmd_code), 32'h7);
      @(negedge clk); #1;
      chk("R6 both cleared", 32'({cu_cmd_code, ru_cmd_code}), 32'h0);
      cu_cmd_ready = 1'b0; ru_cmd_ready = 1'b0;

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         tests++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule